// File: doc/BRIEF.md
# Reload-Gated Programmable Clock Divider

This block derives one slow clock from a fast parent clock. It divides by an integer ratio held in a small register file. Software places a new ratio in a staging field of the ratio register. The running output keeps its present ratio until software asks for a reload. To do that it first marks this divider as a reload target, then raises the global reload trigger with the target mark still set. The staged value is captured at that moment. It becomes the active ratio at the next end of a full output period, so no shortened pulse is ever produced.

Only ratios 4, 5, 6 and 8 are accepted; a reload of any other staged value is dropped. Even ratios give a 50% duty cycle, and ratio 5 is high for 2 parent cycles and low for 3. A per-clock enable bit gates the output. The gate follows the enable bit only at a period boundary, while the output is low. Once the reload is done, software clears the request bits, and doing so leaves the active ratio alone.

Top module: `clk_ratio_div`

## Requirements
- R1: After reset clk_o is low, the control register reads 0, the ratio register reads 32'h0000_0800 (staged ratio 8), and the active ratio is 8.
- R2: The ratio register sits at byte offset RATIO_OFFSET (4 or 8) from the control register at offset 0. It stores only bits [13:8] as the staged ratio, and reads return that field with every other bit 0. Writing the ratio register alone never changes the output period.
- R3: A reload request is made only by a control write with both bit 1 (reload-force) and bit 8 (reload trigger) set. A control write with only one of those two bits set changes nothing about the active ratio.
- R4: With active ratio r, clk_o repeats every r parent cycles. Each period is high for floor(r/2) cycles and low for r-floor(r/2) cycles.
- R5: A new ratio takes effect only at the end of a full output period. Every high and low run is the length of either the old or the new ratio, and after the switch all periods use the new ratio.
- R6: A reload whose staged value is not in {4, 5, 6, 8} is ignored, and the previous active ratio is kept.
- R7: The enable bit is control bit 1+EN_SHIFT (bit 17 for EN_SHIFT=16). When it is clear, clk_o is held low. Enable and disable take effect only at a period boundary, so every high pulse has full length.
- R8: Clearing the low eight control bits and the trigger after a reload leaves the new active ratio unchanged.
- R9: The control register reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
A reload request can arrive in the same cycle in which the output period wraps. In that case the boundary logic must choose between the request that just came in and any request still pending, and must not cut the running period short. The bench moves the reload sequence across every phase of the old period, for every ordered pair of legal ratios. It logs each completed high and low run at the output. Every run must match the old or the new ratio, and the final runs must match the new one. The enable bit is swept across phases in the same way, and every high pulse must have full length.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int RATIO_W     = 6;
  localparam int RATIO_LSB   = 8;
  localparam int FORCE_BIT   = 1;
  localparam int TRIG_BIT    = 8;
  localparam int RESET_RATIO = 8;

  typedef logic [RATIO_W-1:0] ratio_t;

  function automatic logic ratio_ok(ratio_t r);
    return (r == ratio_t'(4)) || (r == ratio_t'(5)) ||
           (r == ratio_t'(6)) || (r == ratio_t'(8));
  endfunction
endpackage

// File: rtl/clk_ratio_regs.sv
module clk_ratio_regs
  import clk_ratio_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int RATIO_OFFSET = 4,
  parameter int EN_SHIFT     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              enable_o,
  output logic              req_valid_o,
  output ratio_t            req_ratio_o
);
  localparam int EN_BIT = FORCE_BIT + EN_SHIFT;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(RATIO_OFFSET);

  logic [DATA_W-1:0] ctrl_q;
  ratio_t            staged_q;
  logic              req_q;
  ratio_t            req_ratio_q;
  logic              sel_ctrl, sel_ratio, reload_hit;

  assign sel_ctrl   = wr_i && (addr_i == CTRL_ADDR);
  assign sel_ratio  = wr_i && (addr_i == RATIO_ADDR);
  assign reload_hit = sel_ctrl && wdata_i[TRIG_BIT] && wdata_i[FORCE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      staged_q    <= ratio_t'(RESET_RATIO);
      req_q       <= 1'b0;
      req_ratio_q <= ratio_t'(RESET_RATIO);
    end else begin
      req_q <= 1'b0;
      if (sel_ctrl) ctrl_q <= wdata_i;
      if (sel_ratio) staged_q <= wdata_i[RATIO_LSB +: RATIO_W];
      // capture staged value at trigger time; illegal values are dropped
      if (reload_hit && ratio_ok(staged_q)) begin
        req_q       <= 1'b1;
        req_ratio_q <= staged_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = ctrl_q;
    else if (addr_i == RATIO_ADDR) rdata_o[RATIO_LSB +: RATIO_W] = staged_q;
  end

  assign enable_o    = ctrl_q[EN_BIT];
  assign req_valid_o = req_q;
  assign req_ratio_o = req_ratio_q;

  assert_req_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(wr_i && (addr_i == CTRL_ADDR) && wdata_i[TRIG_BIT] && wdata_i[FORCE_BIT]));
  assert_req_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> ratio_ok(req_ratio_o));
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   enable_i,
  input  logic   req_valid_i,
  input  ratio_t req_ratio_i,
  output logic   clk_o
);
  ratio_t act_q, cnt_q, pend_ratio_q;
  logic   pend_q, gate_q, clk_q;
  ratio_t act_n, cnt_n;
  logic   gate_n, clk_n, wrap;

  assign wrap = (cnt_q == act_q - ratio_t'(1));

  always_comb begin
    cnt_n  = cnt_q + ratio_t'(1);
    act_n  = act_q;
    gate_n = gate_q;
    if (wrap) begin
      cnt_n  = '0;
      gate_n = enable_i;
      if (req_valid_i) act_n = req_ratio_i;
      else if (pend_q) act_n = pend_ratio_q;
    end
    // high for floor(r/2) cycles at the start of each period
    clk_n = gate_n && (cnt_n < (act_n >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q        <= ratio_t'(RESET_RATIO);
      cnt_q        <= '0;
      gate_q       <= 1'b0;
      clk_q        <= 1'b0;
      pend_q       <= 1'b0;
      pend_ratio_q <= ratio_t'(RESET_RATIO);
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      gate_q <= gate_n;
      clk_q  <= clk_n;
      if (wrap) pend_q <= 1'b0;
      else if (req_valid_i) begin
        pend_q       <= 1'b1;
        pend_ratio_q <= req_ratio_i;
      end
    end
  end

  assign clk_o = clk_q;

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);
  assert_ratio_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_ok(act_q));
  assert_switch_at_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != act_q - ratio_t'(1)) |=> $stable(act_q));
  assert_gate_in_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_q |=> $stable(gate_q));
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
  import clk_ratio_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 32,
  parameter int RATIO_OFFSET = 4,
  parameter int EN_SHIFT     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_o
);
  logic   enable;
  logic   req_valid;
  ratio_t req_ratio;

  clk_ratio_regs #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RATIO_OFFSET(RATIO_OFFSET),
    .EN_SHIFT    (EN_SHIFT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .enable_o   (enable),
    .req_valid_o(req_valid),
    .req_ratio_o(req_ratio)
  );

  clk_ratio_gen u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable),
    .req_valid_i(req_valid),
    .req_ratio_i(req_ratio),
    .clk_o      (clk_o)
  );
endmodule

// File: tb/clk_ratio_div_bench.sv
`timescale 1ns/1ps
module clk_ratio_div_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int ROFF   = 4;
  localparam int ESH    = 16;
  localparam logic [31:0] EN = 32'h1 << (1 + ESH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic clk_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int run_len [0:511];
  bit run_lvl [0:511];
  int n_runs = 0;
  int cur_len = 0;
  bit cur_lvl = 1'b0;
  bit partial = 1'b1;

  always #2 clk = ~clk;

  clk_ratio_div #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_OFFSET(ROFF), .EN_SHIFT(ESH)) u_clk_ratio_div (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .clk_o(clk_out)
  );

  // run-length monitor sampled away from the active edge
  always @(negedge clk) begin
    if (clk_out == cur_lvl) cur_len++;
    else begin
      if (!partial && n_runs < 512) begin
        run_len[n_runs] = cur_len;
        run_lvl[n_runs] = cur_lvl;
        n_runs++;
      end
      partial = 1'b0;
      cur_lvl = clk_out;
      cur_len = 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr_reg(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_log();
    @(negedge clk);
    #1;
    n_runs = 0;
    partial = 1'b1;
  endtask

  task automatic reload(int r);
    wr_reg(ADDR_W'(ROFF), 32'(r) << 8);
    wr_reg('0, EN | 32'h2);
    wr_reg('0, EN | 32'h102);
    wr_reg('0, EN);
  endtask

  // all logged runs must match ratio r exactly
  task automatic check_steady(int r, string req);
    int h, l, bad_len, bad_exp;
    bit ok;
    h = r / 2; l = r - h;
    clear_log();
    repeat (6 * r + 4) @(negedge clk);
    ok = (n_runs >= 4);
    bad_len = n_runs; bad_exp = 4;
    for (int i = 0; i < n_runs; i++) begin
      if (run_len[i] != (run_lvl[i] ? h : l)) begin
        if (ok) begin bad_len = run_len[i]; bad_exp = run_lvl[i] ? h : l; end
        ok = 1'b0;
      end
    end
    chk(ok, req, $sformatf("steady run length at ratio %0d", r), bad_len, bad_exp);
  endtask

  localparam int RATIOS [4] = '{4, 5, 6, 8};

  initial begin
    logic [31:0] d;
    bit ok;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R1", "clk_o low after reset", int'(ok), 1);
    rd_reg('0, d);
    chk(d == 32'h0, "R1", "control reset value", int'(d), 0);
    rd_reg(ADDR_W'(ROFF), d);
    chk(d == 32'h800, "R1", "ratio reset value", int'(d), 32'h800);

    // R9: control readback; R7/R1: enable shows ratio 8
    wr_reg('0, EN);
    rd_reg('0, d);
    chk(d == EN, "R9", "control readback", int'(d), int'(EN));
    check_steady(8, "R1");

    // R2: staged field only, no effect before reload
    wr_reg(ADDR_W'(ROFF), 32'hFFFF_C5FF);
    rd_reg(ADDR_W'(ROFF), d);
    chk(d == 32'h0000_0500, "R2", "ratio field readback", int'(d), 32'h500);
    check_steady(8, "R2");

    // R3: trigger without force, force without trigger
    wr_reg('0, EN | 32'h100);
    check_steady(8, "R3");
    wr_reg('0, EN | 32'h2);
    wr_reg('0, EN);
    check_steady(8, "R3");

    // R4: every legal ratio
    foreach (RATIOS[k]) begin
      reload(RATIOS[k]);
      repeat (20) @(negedge clk);
      check_steady(RATIOS[k], "R4");
    end

    // R8: request bits cleared afterwards
    reload(6);
    repeat (20) @(negedge clk);
    wr_reg('0, EN | 32'h0);
    wr_reg('0, EN | 32'h0FD);
    wr_reg('0, EN);
    check_steady(6, "R8");

    // R6: illegal staged values are dropped
    reload(7);
    repeat (20) @(negedge clk);
    check_steady(6, "R6");
    reload(63);
    repeat (20) @(negedge clk);
    check_steady(6, "R6");
    reload(0);
    repeat (20) @(negedge clk);
    check_steady(6, "R6");

    // R5: reload swept over old/new pairs and phases
    foreach (RATIOS[a]) begin
      foreach (RATIOS[b]) begin
        for (int ph = 0; ph < 8; ph++) begin
          int ho, lo, hn, ln;
          reload(RATIOS[a]);
          repeat (20) @(negedge clk);
          ho = RATIOS[a] / 2; lo = RATIOS[a] - ho;
          hn = RATIOS[b] / 2; ln = RATIOS[b] - hn;
          repeat (ph) @(negedge clk);
          clear_log();
          reload(RATIOS[b]);
          repeat (48) @(negedge clk);
          ok = (n_runs >= 4);
          bad = -1;
          for (int i = 0; i < n_runs; i++) begin
            if (run_lvl[i] ? (run_len[i] != ho && run_len[i] != hn)
                           : (run_len[i] != lo && run_len[i] != ln)) begin
              if (ok) bad = run_len[i];
              ok = 1'b0;
            end
          end
          for (int i = n_runs - 2; i < n_runs; i++) begin
            if (i >= 0 && run_len[i] != (run_lvl[i] ? hn : ln)) begin
              if (ok) bad = run_len[i];
              ok = 1'b0;
            end
          end
          chk(ok, "R5", $sformatf("switch %0d->%0d phase %0d run", RATIOS[a], RATIOS[b], ph),
              bad, RATIOS[b]);
        end
      end
    end

    // R7: gating swept over phases at ratio 5
    reload(5);
    repeat (20) @(negedge clk);
    for (int ph = 0; ph < 5; ph++) begin
      repeat (ph) @(negedge clk);
      clear_log();
      wr_reg('0, 32'h0);
      repeat (12) @(negedge clk);
      ok = 1'b1; bad = -1;
      for (int i = 0; i < n_runs; i++)
        if (run_len[i] != (run_lvl[i] ? 2 : 3)) begin ok = 1'b0; bad = run_len[i]; end
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (clk_out !== 1'b0) begin ok = 1'b0; bad = 99; end
      end
      chk(ok, "R7", $sformatf("disable at phase %0d", ph), bad, 0);
      repeat (ph) @(negedge clk);
      clear_log();
      wr_reg('0, EN);
      repeat (30) @(negedge clk);
      ok = (n_runs >= 4); bad = n_runs;
      for (int i = 0; i < n_runs; i++)
        if (run_len[i] != (run_lvl[i] ? 2 : 3)) begin ok = 1'b0; bad = run_len[i]; end
      chk(ok, "R7", $sformatf("enable at phase %0d", ph), bad, 2);
    end

    finish_test();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
    finish_test();
  end
endmodule